// File: doc/BRIEF.md
# Bus Cycle Trace Capture for a Status Display

This block watches the lines of a parallel backplane bus and keeps a snapshot of the most recent bus cycle. Its outputs drive a row of status lamps and two half-word readback registers. The address phase fields are taken when the address strobe goes active: the address, the address modifier code, the interrupt-acknowledge flag, the write flag and the long-word flag. The data word and the kind of termination are taken when the cycle ends. The termination is either a normal acknowledge or a bus error.

Bus-request activity and system reset are short events, often only one clock long. Each one is stretched into a lamp pulse of a fixed number of clocks, so that a person can see it. All inputs are active-high levels that are already synchronised to `clk`. Lamp electrical drive lies outside the block.

Top module: `bus_trace_display`

## Requirements
- R1: On every clock where `busAs` is high after being low on the previous clock, `capAddr`, `capAm`, `capIack`, `capWrite` and `capLword` take the bus values of that clock and show them from the next clock.
- R2: The address-phase outputs of R1 do not change on any clock without a new rising `busAs`.
- R3: `capData` takes `busData` on a clock where `busDtack` or `busBerr` has become active (neither was active on the previous clock) while `busDs` is high. A termination rise with `busDs` low is ignored, and `capData` keeps its value otherwise.
- R4: A capture under R3 sets `termBerr` when `busBerr` is high and otherwise sets `termDtack`. Bus error wins when both are high. Both flags clear on a rising `busAs`, and they are never high together.
- R5: `dataHi` equals `capData[31:16]` and `dataLo` equals `capData[15:0]`.
- R6: `brqLed` is high starting the clock after any bit of `busBr` is sampled high. It stays high until FLASH_HOLD (default 16) clocks have passed with no request sampled.
- R7: `sresLed` follows the same stretch rule as R6, driven by `busSysres`.
- R8: A synchronous `rst` clears every captured field, both termination flags and both lamps.
- R9: `ledDrive` is 77 bits with this layout: [76:45] address, [44:13] data, [12:7] modifier, [6] iack, [5] write, [4] lword, [3] acknowledge flag, [2] bus-error flag, [1] request lamp, [0] reset lamp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busAddr | input | 32 | Bus address lines |
| busData | input | 32 | Bus data lines |
| busAm | input | 6 | Address modifier lines |
| busAs | input | 1 | Address strobe, active high |
| busDs | input | 1 | Data strobe (any), active high |
| busDtack | input | 1 | Slave acknowledge, active high |
| busBerr | input | 1 | Bus error, active high |
| busBr | input | 4 | Bus request lines |
| busSysres | input | 1 | System reset line |
| busIack | input | 1 | Interrupt-acknowledge line |
| busWrite | input | 1 | Write line |
| busLword | input | 1 | Long-word line |
| capAddr | output | 32 | Captured address |
| capAm | output | 6 | Captured modifier |
| capIack | output | 1 | Captured iack |
| capWrite | output | 1 | Captured write |
| capLword | output | 1 | Captured long-word |
| capData | output | 32 | Captured data |
| termDtack | output | 1 | Last cycle ended by acknowledge |
| termBerr | output | 1 | Last cycle ended by bus error |
| brqLed | output | 1 | Stretched bus-request lamp |
| sresLed | output | 1 | Stretched system-reset lamp |
| dataHi | output | 16 | Upper half of captured data |
| dataLo | output | 16 | Lower half of captured data |
| ledDrive | output | 77 | All lamp bits packed |

## Verification
A stale edge history shows up at the ports within one clock. Either a snapshot is missed or a second one is taken mid-cycle, and `capAddr` or `capData` then differs from a model that tracks the previous line levels. A bad stretch counter shows up in the clock after the last request, or at the end of the hold window, when `brqLed` or `sresLed` drops early or stays high too long. Since the bench compares every output on every clock, each such fault is reported in the cycle it first appears.

// File: rtl/bus_trace_pkg.sv
package bus_trace_pkg;
  // Strobes the control half hands to the capture registers each clock.
  typedef struct packed {
    logic headCapture;  // address strobe just went active
    logic tailCapture;  // termination just arrived with a data strobe
    logic tailIsBerr;   // that termination was a bus error
  } traceStrobe_t;
endpackage

// File: rtl/bus_trace_ctrl.sv
module bus_trace_ctrl
  import bus_trace_pkg::*;
(
  input  logic         clk,
  input  logic         busAs,
  input  logic         busDs,
  input  logic         busDtack,
  input  logic         busBerr,
  output traceStrobe_t strobe
);
  logic asPrev;
  logic termPrev;
  logic termNow;

  assign termNow = busDtack | busBerr;

  // Edge history follows the lines through reset so that the first
  // post-reset edge is judged against the true prior level.
  always_ff @(posedge clk) begin
    asPrev   <= busAs;
    termPrev <= termNow;
  end

  always_comb begin
    strobe.headCapture = busAs & ~asPrev;
    strobe.tailCapture = termNow & ~termPrev & busDs;
    strobe.tailIsBerr  = busBerr;
  end
endmodule

// File: rtl/bus_trace_flash.sv
module bus_trace_flash #(
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic trigger,
  output logic lit
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);

  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst)                 remain <= '0;
    else if (trigger)        remain <= CNT_W'(HOLD_CYCLES);
    else if (remain != '0)   remain <= remain - 1'b1;
  end

  assign lit = (remain != '0);
endmodule

// File: rtl/bus_trace_datapath.sv
module bus_trace_datapath
  import bus_trace_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int AM_W   = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  traceStrobe_t      strobe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busData,
  input  logic [AM_W-1:0]   busAm,
  input  logic              busIack,
  input  logic              busWrite,
  input  logic              busLword,
  output logic [ADDR_W-1:0] capAddr,
  output logic [AM_W-1:0]   capAm,
  output logic              capIack,
  output logic              capWrite,
  output logic              capLword,
  output logic [DATA_W-1:0] capData,
  output logic              termDtack,
  output logic              termBerr
);
  always_ff @(posedge clk) begin
    if (rst) begin
      capAddr  <= '0;
      capAm    <= '0;
      capIack  <= 1'b0;
      capWrite <= 1'b0;
      capLword <= 1'b0;
    end else if (strobe.headCapture) begin
      capAddr  <= busAddr;
      capAm    <= busAm;
      capIack  <= busIack;
      capWrite <= busWrite;
      capLword <= busLword;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      capData   <= '0;
      termDtack <= 1'b0;
      termBerr  <= 1'b0;
    end else if (strobe.tailCapture) begin
      // A termination in the same clock as a new address strobe wins.
      capData   <= busData;
      termDtack <= ~strobe.tailIsBerr;
      termBerr  <= strobe.tailIsBerr;
    end else if (strobe.headCapture) begin
      termDtack <= 1'b0;
      termBerr  <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_trace_display.sv
module bus_trace_display
  import bus_trace_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int AM_W       = 6,
  parameter int BR_LINES   = 4,
  parameter int FLASH_HOLD = 16,
  localparam int HALF_W    = DATA_W / 2,
  localparam int LED_W     = ADDR_W + DATA_W + AM_W + 7
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busData,
  input  logic [AM_W-1:0]     busAm,
  input  logic                busAs,
  input  logic                busDs,
  input  logic                busDtack,
  input  logic                busBerr,
  input  logic [BR_LINES-1:0] busBr,
  input  logic                busSysres,
  input  logic                busIack,
  input  logic                busWrite,
  input  logic                busLword,
  output logic [ADDR_W-1:0]   capAddr,
  output logic [AM_W-1:0]     capAm,
  output logic                capIack,
  output logic                capWrite,
  output logic                capLword,
  output logic [DATA_W-1:0]   capData,
  output logic                termDtack,
  output logic                termBerr,
  output logic                brqLed,
  output logic                sresLed,
  output logic [HALF_W-1:0]   dataHi,
  output logic [HALF_W-1:0]   dataLo,
  output logic [LED_W-1:0]    ledDrive
);
  localparam int FLASH_N = 2;

  traceStrobe_t        strobe;
  logic [FLASH_N-1:0]  flashSrc;
  logic [FLASH_N-1:0]  flashLit;

  bus_trace_ctrl u_ctrl (
    .clk(clk), .busAs(busAs), .busDs(busDs),
    .busDtack(busDtack), .busBerr(busBerr), .strobe(strobe)
  );

  bus_trace_datapath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .AM_W(AM_W)) u_datapath (
    .clk(clk), .rst(rst), .strobe(strobe),
    .busAddr(busAddr), .busData(busData), .busAm(busAm),
    .busIack(busIack), .busWrite(busWrite), .busLword(busLword),
    .capAddr(capAddr), .capAm(capAm), .capIack(capIack),
    .capWrite(capWrite), .capLword(capLword), .capData(capData),
    .termDtack(termDtack), .termBerr(termBerr)
  );

  assign flashSrc = {busSysres, |busBr};

  for (genvar i = 0; i < FLASH_N; i++) begin : g_flash
    bus_trace_flash #(.HOLD_CYCLES(FLASH_HOLD)) u_flash (
      .clk(clk), .rst(rst), .trigger(flashSrc[i]), .lit(flashLit[i])
    );
  end

  assign brqLed  = flashLit[0];
  assign sresLed = flashLit[1];

  assign dataHi = capData[DATA_W-1:HALF_W];
  assign dataLo = capData[HALF_W-1:0];

  assign ledDrive = {capAddr, capData, capAm, capIack, capWrite, capLword,
                     termDtack, termBerr, brqLed, sresLed};
endmodule

// File: rtl/bus_trace_checks.sv
module bus_trace_checks #(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int BR_LINES = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [DATA_W-1:0]   busData,
  input logic                busAs,
  input logic                busDs,
  input logic                busDtack,
  input logic                busBerr,
  input logic [BR_LINES-1:0] busBr,
  input logic                busSysres,
  input logic [ADDR_W-1:0]   capAddr,
  input logic [DATA_W-1:0]   capData,
  input logic                termDtack,
  input logic                termBerr,
  input logic                brqLed,
  input logic                sresLed
);
  p_head_capture_r1: assert property (@(posedge clk) disable iff (rst)
    (busAs && !$past(busAs)) |=> (capAddr == $past(busAddr)));

  p_head_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(busAs && !$past(busAs)) |=> $stable(capAddr));

  p_tail_data_r3: assert property (@(posedge clk) disable iff (rst)
    (busDs && (busDtack || busBerr) && !$past(busDtack || busBerr))
      |=> (capData == $past(busData)));

  p_berr_wins_r4: assert property (@(posedge clk) disable iff (rst)
    (busDs && busBerr && !$past(busDtack || busBerr)) |=> (termBerr && !termDtack));

  p_flags_exclusive_r4: assert property (@(posedge clk) disable iff (rst)
    !(termDtack && termBerr));

  p_brq_flash_r6: assert property (@(posedge clk) disable iff (rst)
    (|busBr) |=> brqLed);

  p_sres_flash_r7: assert property (@(posedge clk) disable iff (rst)
    busSysres |=> sresLed);

  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (capAddr == '0 && capData == '0 && !termDtack && !termBerr));
endmodule

bind bus_trace_display bus_trace_checks #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BR_LINES(BR_LINES)
) u_checks (
  .clk(clk), .rst(rst), .busAddr(busAddr), .busData(busData),
  .busAs(busAs), .busDs(busDs), .busDtack(busDtack), .busBerr(busBerr),
  .busBr(busBr), .busSysres(busSysres), .capAddr(capAddr), .capData(capData),
  .termDtack(termDtack), .termBerr(termBerr), .brqLed(brqLed), .sresLed(sresLed)
);

// File: tb/bus_trace_display_bench.sv
module bus_trace_display_bench;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst;
  logic [31:0] busAddr, busData;
  logic [5:0]  busAm;
  logic        busAs, busDs, busDtack, busBerr, busSysres, busIack, busWrite, busLword;
  logic [3:0]  busBr;
  logic [31:0] capAddr, capData;
  logic [5:0]  capAm;
  logic        capIack, capWrite, capLword, termDtack, termBerr, brqLed, sresLed;
  logic [15:0] dataHi, dataLo;
  logic [76:0] ledDrive;

  bus_trace_display #(.FLASH_HOLD(HOLD)) u_bus_trace_display (
    .clk(clk), .rst(rst), .busAddr(busAddr), .busData(busData), .busAm(busAm),
    .busAs(busAs), .busDs(busDs), .busDtack(busDtack), .busBerr(busBerr),
    .busBr(busBr), .busSysres(busSysres), .busIack(busIack), .busWrite(busWrite),
    .busLword(busLword), .capAddr(capAddr), .capAm(capAm), .capIack(capIack),
    .capWrite(capWrite), .capLword(capLword), .capData(capData),
    .termDtack(termDtack), .termBerr(termBerr), .brqLed(brqLed), .sresLed(sresLed),
    .dataHi(dataHi), .dataLo(dataLo), .ledDrive(ledDrive)
  );

  // Reference model state
  logic [31:0] mAddr, mData;
  logic [5:0]  mAm;
  logic        mIack, mWrite, mLword, mDtk, mBerr;
  int          mBrqRem, mSresRem;
  logic        mPrevAs, mPrevTerm;

  int checks = 0;
  int errors = 0;

  task automatic chk(input string tag, input logic [79:0] act, input logic [79:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic modelEdge();
    logic headNow, termNow, tailNow;
    headNow = busAs && !mPrevAs;
    termNow = busDtack || busBerr;
    tailNow = termNow && !mPrevTerm && busDs;
    if (rst) begin
      mAddr = 0; mData = 0; mAm = 0; mIack = 0; mWrite = 0; mLword = 0;
      mDtk = 0; mBerr = 0; mBrqRem = 0; mSresRem = 0;
    end else begin
      if (headNow) begin
        mAddr = busAddr; mAm = busAm; mIack = busIack; mWrite = busWrite; mLword = busLword;
        mDtk = 0; mBerr = 0;
      end
      if (tailNow) begin
        mData = busData; mBerr = busBerr; mDtk = !busBerr;
      end
      if (busBr != 0) mBrqRem = HOLD; else if (mBrqRem > 0) mBrqRem--;
      if (busSysres)  mSresRem = HOLD; else if (mSresRem > 0) mSresRem--;
    end
    mPrevAs = busAs;
    mPrevTerm = termNow;
  endtask

  task automatic compareAll();
    logic [76:0] expLed;
    expLed = {mAddr, mData, mAm, mIack, mWrite, mLword, mDtk, mBerr,
              (mBrqRem > 0), (mSresRem > 0)};
    chk("R1 capAddr", 80'(capAddr), 80'(mAddr));
    chk("R1 capAm", 80'(capAm), 80'(mAm));
    chk("R1 iack/write/lword", 80'({capIack, capWrite, capLword}), 80'({mIack, mWrite, mLword}));
    chk("R3 capData", 80'(capData), 80'(mData));
    chk("R4 flags", 80'({termDtack, termBerr}), 80'({mDtk, mBerr}));
    chk("R5 dataHi", 80'(dataHi), 80'(mData[31:16]));
    chk("R5 dataLo", 80'(dataLo), 80'(mData[15:0]));
    chk("R6 brqLed", 80'(brqLed), 80'(mBrqRem > 0));
    chk("R7 sresLed", 80'(sresLed), 80'(mSresRem > 0));
    chk("R9 ledDrive", 80'(ledDrive), 80'(expLed));
  endtask

  task automatic tick();
    @(posedge clk);
    modelEdge();
    #1;
    compareAll();
    @(negedge clk);
  endtask

  task automatic idle();
    busAs = 0; busDs = 0; busDtack = 0; busBerr = 0; busBr = 0; busSysres = 0;
  endtask

  // One full bus cycle: address phase, data strobe, termination, release
  task automatic busCycle(input logic [31:0] a, input logic [5:0] am, input logic wr,
                          input logic [31:0] d, input logic useBerr, input logic bothTerm);
    busAddr = a; busAm = am; busWrite = wr; busIack = 0; busLword = 1; busAs = 1;
    tick(); tick();
    busDs = 1; busData = d;
    tick();
    busDtack = !useBerr || bothTerm; busBerr = useBerr;
    tick();
    busAddr = ~a; busData = ~d;   // later changes must not leak in (R2, R3)
    tick();
    idle();
    tick();
  endtask

  initial begin
    mPrevAs = 0; mPrevTerm = 0;
    mAddr = 0; mData = 0; mAm = 0; mIack = 0; mWrite = 0; mLword = 0;
    mDtk = 0; mBerr = 0; mBrqRem = 0; mSresRem = 0;
    rst = 1; busAddr = 0; busData = 0; busAm = 0; busIack = 0; busWrite = 0; busLword = 0;
    idle();
    @(negedge clk);
    repeat (3) tick();
    chk("R8 reset state", 80'(ledDrive), 80'(0));
    rst = 0;
    tick();

    busCycle(32'hDEAD_BEEF, 6'h09, 1, 32'h1234_5678, 0, 0);
    chk("R3 acked data", 80'(capData), 80'(32'h1234_5678));
    chk("R4 dtack flag", 80'({termDtack, termBerr}), 80'(2'b10));
    chk("R5 upper half", 80'(dataHi), 80'(16'h1234));
    busCycle(32'h00C0_FFEE, 6'h3D, 0, 32'hCAFE_F00D, 1, 0);
    chk("R4 berr flag", 80'({termDtack, termBerr}), 80'(2'b01));
    busCycle(32'h5555_AAAA, 6'h2A, 1, 32'h0BAD_0BAD, 1, 1);
    chk("R4 berr wins", 80'({termDtack, termBerr}), 80'(2'b01));

    // Termination without data strobe is ignored
    busAddr = 32'h7777_0000; busAs = 1; tick();
    chk("R4 flags cleared by new strobe", 80'({termDtack, termBerr}), 80'(0));
    busData = 32'h9999_9999; busDtack = 1; tick(); tick();
    chk("R3 no ds ignored", 80'(capData), 80'(32'h0BAD_0BAD));
    idle(); tick();

    // One-clock request and reset pulses
    busBr = 4'b0100; tick(); busBr = 0;
    chk("R6 brq lit", 80'(brqLed), 80'(1));
    repeat (HOLD - 1) tick();
    chk("R6 brq still lit at end", 80'(brqLed), 80'(1));
    tick();
    chk("R6 brq dark after hold", 80'(brqLed), 80'(0));
    busSysres = 1; repeat (5) tick(); busSysres = 0;
    repeat (HOLD + 2) tick();
    chk("R7 sres dark after hold", 80'(sresLed), 80'(0));

    // Random traffic compared each clock
    for (int i = 0; i < 3000; i++) begin
      busAddr   = $urandom;
      busData   = $urandom;
      busAm     = 6'($urandom);
      busIack   = 1'($urandom);
      busWrite  = 1'($urandom);
      busLword  = 1'($urandom);
      busAs     = ($urandom % 4) != 0;
      busDs     = ($urandom % 3) != 0;
      busDtack  = ($urandom % 3) == 0;
      busBerr   = ($urandom % 7) == 0;
      busBr     = (($urandom % 9) == 0) ? 4'($urandom) : 4'd0;
      busSysres = ($urandom % 40) == 0;
      rst       = ($urandom % 500) == 0;
      tick();
    end
    rst = 1; tick(); rst = 0; idle(); tick();
    chk("R8 reset after traffic", 80'(ledDrive), 80'(0));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog expired at %0t", $time);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule